// File: doc/BRIEF.md
# Decode-Stage Branch Direction Predictor

This block predicts the direction of conditional branches once an instruction has been decoded. It keeps a table of two-bit saturating counters, one per slot, and selects a slot from the word-address bits of the instruction's PC just above the two always-zero byte bits. When the decoder reports a conditional branch and the selected counter leans towards taken, the block forms the branch target by adding the sign-extended, word-scaled offset to the PC. In every other case it supplies the sequential address PC+4.

The pipeline reads the predicted next PC and a predict-taken flag in the same cycle as the lookup, with no clock in between. The execute stage later reports each resolved branch on a separate update port: a valid strobe, the branch PC and the actual outcome. The block then moves the selected counter one step towards that outcome. The table holds no tags and no targets, so branches whose PCs share index bits share one counter.

Top module: `bpd_dir_predictor`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not-taken), so a branch lookup at any PC gives pr_taken = 0 and pr_next_pc = lk_pc + 4.
- R2: When lk_is_br = 0, pr_taken is 0 and pr_next_pc is lk_pc + 4, whatever the counter holds.
- R3: When lk_is_br = 1 and bit 1 (the high bit) of the selected counter is 1 (2'b10 or 2'b11), pr_taken is 1 and pr_next_pc is lk_pc plus the sign-extended lk_off shifted left by two.
- R4: An update with up_taken = 1 raises the counter by one and holds it at 2'b11. After any number of taken updates, one not-taken update still leaves a taken prediction.
- R5: An update with up_taken = 0 lowers the counter by one and holds it at 2'b00. After any number of not-taken updates, one taken update still leaves a not-taken prediction.
- R6: The index is PC bits [IDX_W+1:2]. PC bits [1:0] and the bits above the index do not select the slot, so PCs that differ only there share one counter. Other slots are left unchanged.
- R7: When up_valid = 0, up_pc and up_taken change no counter.
- R8: When a lookup and an update select the same slot in one cycle, the lookup sees the counter value from before the update. The new value is seen from the next cycle on.
- R9: A negative offset (lk_off bit 15 = 1) gives a target below lk_pc, for example lk_off = 16'hFFFC gives lk_pc - 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, all counters to weakly not-taken |
| lk_pc | input | ADDR_W | PC of the decoded instruction |
| lk_is_br | input | 1 | Decoded instruction is a conditional branch |
| lk_off | input | OFF_W | Word offset field of the branch |
| pr_taken | output | 1 | Branch is predicted taken |
| pr_next_pc | output | ADDR_W | Predicted next PC |
| up_valid | input | 1 | Resolved branch report is present this cycle |
| up_pc | input | ADDR_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench builds the block with IDX_W = 4, a sixteen-slot table, and keeps ADDR_W = 32 and OFF_W = 16. The small table lets a few directed updates drive a counter into both saturation limits. It also makes aliasing easy to reach, because PCs 64 bytes apart land in the same slot. With the full 16-bit offset width, both signs of displacement and the same-cycle read-before-write case are checked against a bench-side model of the counters.

// File: rtl/bpd_pkg.sv
`timescale 1ns/1ps
package bpd_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'b00;
   localparam ctr_t CTR_WEAK_NT   = 2'b01;
   localparam ctr_t CTR_WEAK_T    = 2'b10;
   localparam ctr_t CTR_STRONG_T  = 2'b11;

   // one saturating step towards the resolved outcome
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return nxt;
   endfunction

   function automatic logic ctr_says_taken(input ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bpd_index.sv
`timescale 1ns/1ps
module bpd_index #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 12
) (
   input  logic [ADDR_W-1:0] pc,
   output logic [IDX_W-1:0]  idx
);
   localparam int LO = 2;
   localparam int HI = IDX_W + LO - 1;

   assign idx = pc[HI:LO];

   logic unused_bits;
   assign unused_bits = ^{pc[LO-1:0], pc[ADDR_W-1:HI+1] & 1'b0};
endmodule

// File: rtl/bpd_counter_table.sv
`timescale 1ns/1ps
module bpd_counter_table
   import bpd_pkg::*;
#(
   parameter int   IDX_W     = 12,
   parameter ctr_t RESET_CTR = CTR_WEAK_NT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   localparam int DEPTH = 1 << IDX_W;

   ctr_t tbl [DEPTH];

   // read is combinational and sees the pre-update value
   assign rd_ctr = tbl[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= RESET_CTR;
      end else if (wr_en) begin
         tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
      end
   end
endmodule

// File: rtl/bpd_target_gen.sv
`timescale 1ns/1ps
module bpd_target_gen #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [OFF_W-1:0]  off,
   input  logic              use_target,
   output logic [ADDR_W-1:0] next_pc
);
   localparam int SCALED_W = OFF_W + 2;
   localparam int EXT_W    = ADDR_W - SCALED_W;

   logic [ADDR_W-1:0] disp;

   generate
      if (EXT_W > 0) begin : g_sext
         assign disp = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
      end else begin : g_exact
         assign disp = {off, 2'b00};
      end
   endgenerate

   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] tgt_pc;
   assign seq_pc  = pc + ADDR_W'(4);
   assign tgt_pc  = pc + disp;
   assign next_pc = use_target ? tgt_pc : seq_pc;
endmodule

// File: rtl/bpd_dir_predictor.sv
`timescale 1ns/1ps
module bpd_dir_predictor
   import bpd_pkg::*;
#(
   parameter int   ADDR_W    = 32,
   parameter int   IDX_W     = 12,
   parameter int   OFF_W     = 16,
   parameter ctr_t RESET_CTR = CTR_WEAK_NT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   input  logic              lk_is_br,
   input  logic [OFF_W-1:0]  lk_off,
   output logic              pr_taken,
   output logic [ADDR_W-1:0] pr_next_pc,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic              up_taken
);
   generate
      if (IDX_W < 1 || IDX_W + 2 > ADDR_W) begin : g_bad_idx
         $error("bpd_dir_predictor: IDX_W must be at least 1 and fit above the byte bits of ADDR_W");
      end
      if (OFF_W < 1 || OFF_W + 2 > ADDR_W) begin : g_bad_off
         $error("bpd_dir_predictor: OFF_W plus two must not exceed ADDR_W");
      end
      if (IDX_W > 16) begin : g_bad_depth
         $error("bpd_dir_predictor: IDX_W above 16 gives an unreasonable table");
      end
   endgenerate

   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] up_idx;
   ctr_t             lk_ctr;
   logic             go_target;

   bpd_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_index (
      .pc (lk_pc),
      .idx(lk_idx)
   );

   bpd_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_up_index (
      .pc (up_pc),
      .idx(up_idx)
   );

   bpd_counter_table #(.IDX_W(IDX_W), .RESET_CTR(RESET_CTR)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_idx),
      .rd_ctr  (lk_ctr),
      .wr_en   (up_valid),
      .wr_idx  (up_idx),
      .wr_taken(up_taken)
   );

   assign go_target = lk_is_br & ctr_says_taken(lk_ctr);

   bpd_target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_target (
      .pc        (lk_pc),
      .off       (lk_off),
      .use_target(go_target),
      .next_pc   (pr_next_pc)
   );

   assign pr_taken = go_target;
endmodule

// File: rtl/bpd_dir_predictor_chk.sv
`timescale 1ns/1ps
module bpd_dir_predictor_chk #(
   parameter int   ADDR_W    = 32,
   parameter int   IDX_W     = 12,
   parameter int   OFF_W     = 16,
   parameter logic [1:0] RESET_CTR = 2'b01
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] lk_pc,
   input logic              lk_is_br,
   input logic [OFF_W-1:0]  lk_off,
   input logic              pr_taken,
   input logic [ADDR_W-1:0] pr_next_pc,
   input logic              up_valid,
   input logic [ADDR_W-1:0] up_pc,
   input logic              up_taken
);
   localparam int EXT_W = ADDR_W - OFF_W - 2;

   logic [IDX_W-1:0]  c_lk_idx, c_up_idx, prev_idx;
   logic [ADDR_W-1:0] c_disp;
   logic              armed, prev_t_seen, prev_nt_seen;
   logic [1:0]        unused_rc;

   assign unused_rc = RESET_CTR;
   assign c_lk_idx  = lk_pc[IDX_W+1:2];
   assign c_up_idx  = up_pc[IDX_W+1:2];
   assign c_disp    = ADDR_W'({{(EXT_W + 1){lk_off[OFF_W-1]}}, lk_off, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed        <= 1'b0;
         prev_t_seen  <= 1'b0;
         prev_nt_seen <= 1'b0;
         prev_idx     <= '0;
      end else begin
         armed        <= 1'b1;
         prev_idx     <= c_up_idx;
         prev_t_seen  <= up_valid && up_taken && lk_is_br && pr_taken && (c_lk_idx == c_up_idx);
         prev_nt_seen <= up_valid && !up_taken && lk_is_br && !pr_taken && (c_lk_idx == c_up_idx);
      end
   end

   // R2
   nonbr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_is_br |-> (!pr_taken && pr_next_pc == lk_pc + ADDR_W'(4)));

   // R3
   taken_needs_br_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pr_taken |-> lk_is_br);

   // R3
   taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pr_taken |-> (pr_next_pc == lk_pc + c_disp));

   // R4
   sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && prev_t_seen && lk_is_br && c_lk_idx == prev_idx) |-> pr_taken);

   // R5
   sat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && prev_nt_seen && lk_is_br && c_lk_idx == prev_idx) |-> !pr_taken);
endmodule

bind bpd_dir_predictor bpd_dir_predictor_chk #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .RESET_CTR(RESET_CTR)
) u_chk (.*);

// File: tb/test_bpd_dir_predictor.sv
`timescale 1ns/1ps
module test_bpd_dir_predictor;
   localparam int AW = 32;
   localparam int IW = 4;
   localparam int OW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] lk_pc = '0;
   logic          lk_is_br = 1'b0;
   logic [OW-1:0] lk_off = '0;
   logic          pr_taken;
   logic [AW-1:0] pr_next_pc;
   logic          up_valid = 1'b0;
   logic [AW-1:0] up_pc = '0;
   logic          up_taken = 1'b0;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic [1:0] m [1 << IW];

   always #5 clk = ~clk;

   bpd_dir_predictor #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW)) i_bpd_dir_predictor (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_is_br(lk_is_br), .lk_off(lk_off),
      .pr_taken(pr_taken), .pr_next_pc(pr_next_pc),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
   );

   function automatic int slot(input logic [AW-1:0] pc);
      return int'(pc[IW+1:2]);
   endfunction

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive a lookup at the falling edge and compare against the model
   task automatic look(input logic [AW-1:0] pc, input logic br, input logic [OW-1:0] off,
                       input string req);
      logic          et;
      logic [AW-1:0] en;
      @(negedge clk);
      lk_pc = pc; lk_is_br = br; lk_off = off;
      #1;
      et = br && m[slot(pc)][1];
      en = et ? pc + {{(AW-OW-2){off[OW-1]}}, off, 2'b00} : pc + 32'd4;
      chk({req, " taken"}, AW'(pr_taken), AW'(et));
      chk({req, " next_pc"}, pr_next_pc, en);
   endtask

   task automatic upd(input logic [AW-1:0] pc, input logic t);
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_taken = t;
      @(posedge clk);
      if (t) m[slot(pc)] = (m[slot(pc)] == 2'b11) ? 2'b11 : m[slot(pc)] + 2'd1;
      else   m[slot(pc)] = (m[slot(pc)] == 2'b00) ? 2'b00 : m[slot(pc)] - 2'd1;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic t_reset;
      look(32'h0000_0100, 1'b1, 16'h0010, "R1 reset slot0");
      look(32'h0000_013C, 1'b1, 16'h0020, "R1 reset slot15");
      look(32'h8000_0018, 1'b1, 16'hFFF0, "R1 reset slot6");
   endtask

   task automatic t_nonbranch;
      upd(32'h0000_0204, 1'b1);
      upd(32'h0000_0204, 1'b1);
      look(32'h0000_0204, 1'b0, 16'h0040, "R2 non-branch on taken slot");
      look(32'h0000_0204, 1'b1, 16'h0040, "R3 branch on taken slot");
   endtask

   task automatic t_neg_off;
      look(32'h0000_0204, 1'b1, 16'hFFFC, "R9 negative offset");
      chk("R9 target below pc", pr_next_pc, 32'h0000_01F4);
   endtask

   task automatic t_sat_up;
      for (int i = 0; i < 5; i++) upd(32'h0000_0008, 1'b1);
      upd(32'h0000_0008, 1'b0);
      look(32'h0000_0008, 1'b1, 16'h0100, "R4 one not-taken after saturation");
      upd(32'h0000_0008, 1'b0);
      look(32'h0000_0008, 1'b1, 16'h0100, "R4 second not-taken");
   endtask

   task automatic t_sat_down;
      for (int i = 0; i < 5; i++) upd(32'h0000_000C, 1'b0);
      upd(32'h0000_000C, 1'b1);
      look(32'h0000_000C, 1'b1, 16'h0008, "R5 one taken after saturation");
      upd(32'h0000_000C, 1'b1);
      look(32'h0000_000C, 1'b1, 16'h0008, "R5 second taken");
   endtask

   task automatic t_alias;
      upd(32'h0000_1047, 1'b1);
      upd(32'h0000_1047, 1'b1);
      look(32'h0000_0004, 1'b1, 16'h0003, "R6 alias low and high bits");
      look(32'h0000_0010, 1'b1, 16'h0003, "R6 neighbour slot untouched");
   endtask

   task automatic t_novalid;
      @(negedge clk);
      up_valid = 1'b0; up_pc = 32'h0000_0014; up_taken = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      up_pc = 32'h0000_0024; up_taken = 1'b0;
      repeat (2) @(posedge clk);
      look(32'h0000_0014, 1'b1, 16'h0005, "R7 no strobe slot5");
      look(32'h0000_0024, 1'b1, 16'h0005, "R7 no strobe slot9");
   endtask

   task automatic t_same_cycle;
      upd(32'h0000_0030, 1'b1);
      @(negedge clk);
      lk_pc = 32'h0000_0030; lk_is_br = 1'b1; lk_off = 16'h0002;
      up_valid = 1'b1; up_pc = 32'h0000_0030; up_taken = 1'b0;
      #1;
      chk("R8 same cycle sees old", AW'(pr_taken), 32'd1);
      @(posedge clk);
      m[12] = 2'b01;
      #1;
      chk("R8 next cycle sees new", AW'(pr_taken), 32'd0);
      chk("R8 next cycle pc", pr_next_pc, 32'h0000_0034);
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < (1 << IW); i++) m[i] = 2'b01;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_nonbranch;
      t_neg_off;
      t_sat_up;
      t_sat_down;
      t_alias;
      t_novalid;
      t_same_cycle;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule